// File: doc/BRIEF.md
# Prescaled PWM Counter with Compare Channels

This block is the timing core of a pulse-width modulator. A wide free-running counter advances by one on each clock, but only while a run condition holds. The run condition is either a continuous enable or a one-shot enable that the hardware clears by itself. A 4-bit scale value picks a 16-bit window out of the counter. That window is compared against four compare registers. Each comparison drives a PWM output and sets a sticky pending flag.

Compare channel 0 can also set the period. With the period-reset bit set, the counter returns to zero on the clock that follows the window matching compare 0. Software reaches the configuration word, the raw count, the scaled count and the four compare values through a plain write-strobe, combinational-read register port.

Top module: `pwm_scaled_timer`

## Requirements
- R1: After reset the counter, the scale, all enables, the period-reset bit, all compare values and all pending flags are zero, so the counter does not move until software enables it.
- R2: The counter holds its value while both the continuous enable (config bit 8) and the one-shot enable (config bit 12) are clear. It increases by exactly one per clock while either of them is set.
- R3: The scaled count equals counter bits [scale+15 : scale], where scale is config bits [3:0]. It is read at byte offset 0x10, and writes to that offset change nothing.
- R4: With the period-reset bit (config bit 9) set, the clock after the scaled count equals compare 0 loads zero into the counter. At scale s this gives a period of (cmp0 << s) + 1 clocks.
- R5: The hardware clears the one-shot enable when the counter returns to zero by itself, through a period reset or a wrap. A counter load from software leaves it set, and a configuration write in the same cycle wins over the hardware clear.
- R6: A software write to the counter (offset 0x08) wins over both the increment and the period reset in the same cycle.
- R7: The counter is 31 bits wide. While running it wraps from 0x7FFFFFFF to 0.
- R8: Output pwm_o[i] is high exactly while the scaled count is greater than or equal to compare value i.
- R9: Pending flag i is set on any clock where pwm_o[i] is high, stays set after that, and takes the written value on a configuration write. It is visible on irq_pend_o[i] and at config bit 28+i.
- R10: Register map: configuration at 0x00, counter at 0x08, scaled count at 0x10, compare i at 0x20+4*i. All of them read back through reg_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 6 | Byte address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pwm_o | output | 4 | Compare outputs, one per channel |
| irq_pend_o | output | 4 | Sticky pending flags, one per channel |

## Verification
The bench follows the counter clock by clock against an arithmetic model while it sweeps scale, compare 0 and the enable mix. This catches a period reset that arrives one clock early or late, and it catches a window taken from the wrong bit offset. The one-shot runs check that the enable drops when a period ends and when the counter wraps, but stays set after a software load; a design that tied the clear to any return to zero fails the load case. Same-cycle collisions, a counter write landing on a compare-0 match, show whether the write wins or is wrongly zeroed. Compare sweeps at two scales check the greater-or-equal edge, where an off-by-one would flip the output one count early. The pending-flag checks show whether the flag stays set once the compare condition has gone away.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int SCALE_W = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;

  localparam logic [ADDR_W-1:0] A_CFG  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CNT  = 6'h08;
  localparam logic [ADDR_W-1:0] A_SCL  = 6'h10;
  localparam logic [ADDR_W-1:0] A_CMP0 = 6'h20;

  localparam int B_ALWAYS  = 8;
  localparam int B_ZCMP    = 9;
  localparam int B_ONESHOT = 12;
  localparam int B_IP0     = 28;
endpackage

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             zero_req_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hw_zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             wrap;

  always_comb begin
    wrap      = run_i && (&cnt_q);
    hw_zero_o = !ld_i && (zero_req_i || wrap);
    cnt_ce    = ld_i || zero_req_i || run_i;
    cnt_d     = cnt_q;
    if (ld_i)            cnt_d = ld_val_i;
    else if (zero_req_i) cnt_d = '0;
    else if (run_i)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !zero_req_i && !run_i) |=> $stable(cnt_q));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !zero_req_i && run_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_req_i && !ld_i) |=> (cnt_q == '0));
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/pwm_window.sv
module pwm_window #(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [CMP_W-1:0]   win_o
);
  logic [CNT_W-1:0] shifted;

  always_comb begin
    shifted = cnt_i >> scale_i;
    win_o   = shifted[CMP_W-1:0];
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] win_i,
  input  logic             cmp_wr_i,
  input  logic [CMP_W-1:0] cmp_val_i,
  input  logic             ip_wr_i,
  input  logic             ip_val_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic             ge_o,
  output logic             ip_o
);
  logic [CMP_W-1:0] cmp_q;
  logic             ip_q, ip_d, ge;

  always_comb begin
    ge   = (win_i >= cmp_q);
    ip_d = ip_wr_i ? ip_val_i : (ip_q | ge);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= cmp_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= 1'b0;
    else        ip_q <= ip_d;
  end

  assign cmp_o = cmp_q;
  assign ge_o  = ge;
  assign ip_o  = ip_q;

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_q && !ip_wr_i) |=> ip_q);
  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ge && !ip_wr_i) |=> ip_q);
  a_r9_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ip_wr_i |=> (ip_q == $past(ip_val_i)));
endmodule

// File: rtl/pwm_scaled_timer.sv
module pwm_scaled_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CMP_W = 16,
  parameter int NCH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    irq_pend_o
);
  localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

  logic [SCALE_W-1:0] scale_q;
  logic               always_q, zcmp_q, os_q, os_d;
  logic               cfg_wr, cnt_wr;
  logic               run, zero_req, hw_zero;
  logic [CNT_W-1:0]   cnt;
  logic [CMP_W-1:0]   win;
  logic [NCH-1:0]     ge, ip;
  logic [NCH-1:0][CMP_W-1:0] cmp_val;
  logic [DATA_W-1:0]  cfg_rd;

  always_comb begin
    cfg_wr   = reg_wr && (reg_addr == A_CFG);
    cnt_wr   = reg_wr && (reg_addr == A_CNT);
    run      = always_q || os_q;
    zero_req = zcmp_q && (win == cmp_val[0]);
    os_d     = os_q;
    if (cfg_wr)       os_d = reg_wdata[B_ONESHOT];
    else if (hw_zero) os_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q  <= '0;
      always_q <= 1'b0;
      zcmp_q   <= 1'b0;
    end else if (cfg_wr) begin
      scale_q  <= reg_wdata[SCALE_W-1:0];
      always_q <= reg_wdata[B_ALWAYS];
      zcmp_q   <= reg_wdata[B_ZCMP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) os_q <= 1'b0;
    else        os_q <= os_d;
  end

  pwm_cnt_core #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .zero_req_i (zero_req),
    .ld_i       (cnt_wr),
    .ld_val_i   (reg_wdata[CNT_W-1:0]),
    .cnt_o      (cnt),
    .hw_zero_o  (hw_zero)
  );

  pwm_window #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_win (
    .cnt_i   (cnt),
    .scale_i (scale_q),
    .win_o   (win)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_cmp_chan #(.CMP_W(CMP_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_i     (win),
      .cmp_wr_i  (reg_wr && (reg_addr == A_CMP0 + ADDR_W'(4 * i))),
      .cmp_val_i (reg_wdata[CMP_W-1:0]),
      .ip_wr_i   (cfg_wr),
      .ip_val_i  (reg_wdata[B_IP0+i]),
      .cmp_o     (cmp_val[i]),
      .ge_o      (ge[i]),
      .ip_o      (ip[i])
    );
  end

  always_comb begin
    cfg_rd                = '0;
    cfg_rd[SCALE_W-1:0]   = scale_q;
    cfg_rd[B_ALWAYS]      = always_q;
    cfg_rd[B_ZCMP]        = zcmp_q;
    cfg_rd[B_ONESHOT]     = os_q;
    for (int i = 0; i < NCH; i++) cfg_rd[B_IP0+i] = ip[i];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:   reg_rdata = cfg_rd;
      A_CNT:   reg_rdata = DATA_W'(cnt);
      A_SCL:   reg_rdata = DATA_W'(win);
      default: begin
        for (int i = 0; i < NCH; i++)
          if (reg_addr == A_CMP0 + ADDR_W'(4 * i)) reg_rdata = DATA_W'(cmp_val[i]);
      end
    endcase
  end

  assign pwm_o      = ge;
  assign irq_pend_o = ip;

  a_r5_os_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_zero && !cfg_wr) |=> !os_q);
  a_r5_os_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (os_q && !hw_zero && !cfg_wr) |=> os_q);
  a_r4_period: assert property (@(posedge clk) disable iff (!rst_n)
    (zcmp_q && (win == cmp_val[0]) && !cnt_wr) |=> (cnt == '0));
  a_r3_scl_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SCL && !run && !zcmp_q) |=> $stable(cnt));
endmodule

// File: tb/sim_pwm_scaled_timer.sv
`timescale 1ns/1ps
module sim_pwm_scaled_timer;
  logic        clk, rst_n, reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [3:0]  pwm_o, irq_pend_o;
  int n_chk, n_bad;
  bit done;

  pwm_scaled_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o),
    .irq_pend_o(irq_pend_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string r, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(int s, bit al, bit zc, bit os);
    logic [31:0] v;
    v = 32'(s & 15);
    v[8] = al; v[9] = zc; v[12] = os;
    return v;
  endfunction

  // Runs the counter from 'start' and follows it with an arithmetic model.
  task automatic run_model(input string r, input int s, input bit al, input bit os,
                           input bit zc, input longint c0, input longint start, input int n);
    longint e;
    bit     eos;
    logic [31:0] v;
    wr(6'h20, 32'(c0));
    wr(6'h00, 32'h0);
    wr(6'h08, 32'(start));
    wr(6'h00, cfgw(s, al, zc, os));
    e = start; eos = os;
    for (int k = 0; k < n; k++) begin
      rd(6'h08, v); chk(r, v, e);
      rd(6'h00, v); chk(r, v[12], eos);
      @(negedge clk);
      if (zc && (((e >> s) & 64'hFFFF) == c0)) begin
        e = 0; eos = 1'b0;
      end else if (al || eos) begin
        if (e == 64'h7FFF_FFFF) begin e = 0; eos = 1'b0; end
        else e = e + 1;
      end
    end
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    logic [31:0] v;
    longint vals[3];
    int cv[4];
    n_chk = 0; n_bad = 0; done = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'h08, v); chk("R1 count", v, 0);
    rd(6'h00, v); chk("R1 cfg", v[12:0], 0);
    rd(6'h20, v); chk("R1 cmp0", v, 0);
    chk("R1 pwm", pwm_o, 4'hF);
    // R2 stopped without enable
    repeat (5) @(negedge clk);
    rd(6'h08, v); chk("R2 held", v, 0);
    // R2 continuous and one-shot counting
    run_model("R2 always", 0, 1, 0, 0, 0, 0, 12);
    run_model("R2 oneshot", 0, 0, 1, 0, 16'hFFFF, 40, 8);
    // R4 period sweep over scale and compare 0
    for (int s = 0; s < 3; s++)
      foreach (cv[p]) run_model("R4 period", s, 1, 0, 1, (p == 3) ? 5 : p, 0, 30);
    // R5 one-shot end on period and replay
    run_model("R5 oneshot", 0, 0, 1, 1, 3, 0, 10);
    run_model("R5 replay", 1, 0, 1, 1, 2, 0, 12);
    // R7 wrap, continuous and one-shot
    run_model("R7 wrap", 0, 1, 0, 0, 0, 64'h7FFF_FFFE, 4);
    run_model("R7 oswrap", 0, 0, 1, 0, 16'hFFFF, 64'h7FFF_FFFE, 4);
    // R6 software load beats the period reset
    wr(6'h20, 5); wr(6'h00, cfgw(0, 1, 1, 0));
    wr(6'h08, 5); wr(6'h08, 100);
    rd(6'h08, v); chk("R6 priority", v, 100);
    // R5 software load leaves one-shot set
    wr(6'h00, cfgw(0, 0, 0, 1));
    repeat (3) @(negedge clk);
    wr(6'h08, 0);
    rd(6'h00, v); chk("R5 swload", v[12], 1);
    // R3 scale sweep on a stopped counter
    vals[0] = 64'h7FFF_FFFF; vals[1] = 64'h1234_5678; vals[2] = 64'h0000_ABCD;
    for (int s = 0; s < 16; s++) begin
      wr(6'h00, cfgw(s, 0, 0, 0));
      foreach (vals[j]) begin
        wr(6'h08, 32'(vals[j]));
        rd(6'h10, v); chk("R3 window", v, (vals[j] >> s) & 64'hFFFF);
      end
    end
    wr(6'h10, 32'hFFFF);
    rd(6'h08, v); chk("R3 ro count", v, 32'h0000_ABCD);
    rd(6'h10, v); chk("R3 ro scl", v, (64'hABCD >> 15) & 64'hFFFF);
    // R8 compare sweep at scale 0 and 3
    cv[0] = 3; cv[1] = 7; cv[2] = 8; cv[3] = 15;
    foreach (cv[i]) wr(6'(32 + 4 * i), 32'(cv[i]));
    rd(6'h28, v); chk("R10 cmp2", v, 8);
    for (int s = 0; s < 4; s += 3) begin
      wr(6'h00, cfgw(s, 0, 0, 0));
      for (int c = 0; c < 40; c++) begin
        wr(6'h08, 32'(c));
        foreach (cv[i]) chk("R8 ge", pwm_o[i], ((c >> s) >= cv[i]) ? 1 : 0);
      end
    end
    // R9 sticky pending
    for (int i = 1; i < 4; i++) wr(6'(32 + 4 * i), 32'hFFFF);
    wr(6'h20, 10); wr(6'h08, 0); wr(6'h00, 0);
    @(negedge clk);
    chk("R9 clear", irq_pend_o, 0);
    wr(6'h08, 12);
    chk("R9 notyet", irq_pend_o[0], 0);
    @(negedge clk);
    chk("R9 set", irq_pend_o[0], 1);
    wr(6'h08, 0);
    @(negedge clk);
    chk("R9 sticky", irq_pend_o[0], 1);
    rd(6'h00, v); chk("R9 cfgbit", v[31:28], 4'h1);
    wr(6'h00, 0);
    chk("R9 wclear", irq_pend_o, 0);
    rd(6'h00, v); chk("R10 cfg", v, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end
endmodule